// File: doc/BRIEF.md
# SPI serial clock timing controller

This block paces a byte-oriented SPI master. A programmable divisor turns the system clock into a tick at twice the serial clock rate, so one tick marks each serial clock edge. A sequencer uses these ticks to step through the parts of a transfer: chip-select setup, the data frame, chip-select hold, the chip-select-inactive gap, and, when chip select is kept asserted, a gap between frames. While the frame runs it produces the SCLK pin, shift and sample strobes for the external shift registers, and an end-of-frame pulse followed one tick later by a delayed end-of-frame pulse.

A transfer is requested by a one-cycle start pulse. The sequencer remembers the pulse until it is idle and the next tick arrives. Once a frame ends, the sequencer checks the transmit-queue-empty flag to decide whether another frame follows without a new start. The surrounding controller uses the busy and chip-select-idle outputs to drive the chip-select pins. It also loads and unloads its shift registers on the strobes.

Top module: `spi_sclk_timer`

## Requirements
- R1: `tick_o` is high whenever the internal divider count has reached `div_i`, so it fires once every `div_i`+1 cycles. The count starts again from zero on the cycle after `div_wr_i` is high.
- R2: With `div_i` equal to 0, `tick_o` is high on every cycle.
- R3: After reset, and whenever the block is idle, `busy_o` is low, `idle_cs_o` is high and `sclk_o` follows `cpol_i` with one cycle of lag.
- R4: A frame lasts 2×L ticks, where L is the effective frame length. `sclk_o` toggles once per tick during the frame and ends the frame back at the `cpol_i` level.
- R5: Within a frame, let h be the index of the half-period, starting at 0. When `cpha_i`=0, `sample_o` pulses on even h and `shift_o` pulses on odd h. When `cpha_i`=1 the two are swapped. The strobes never pulse together, and each pulse appears on the cycle after its tick.
- R6: The effective frame length L equals `frame_len_i` when that value is from 1 to 8. A value of 0, or any value above 8, gives L = 8.
- R7: A start pulse is held pending until the block is idle and a tick arrives. The block then becomes busy and spends 2×`dly_setup_i` ticks in setup with chip select asserted before the frame begins. A setup value of 0 skips the setup.
- R8: Once a frame has ended, and no held frame follows, chip select stays asserted for 2×`dly_hold_i` ticks. It is then inactive (`idle_cs_o` high while busy) for 2×`dly_gap_i` ticks. A zero value skips its phase.
- R9: When `cs_mode_i`=2 (hold) and `txq_empty_i` is low as a frame ends, the block waits 2×`dly_frame_i` ticks with chip select still asserted and then starts the next frame. No hold, gap or setup phase comes between the two frames.
- R10: When `cs_mode_i` has bit 0 set (values 1 and 3, chip select off), `idle_cs_o` stays high at all times.
- R11: `eof_o` pulses for one cycle after the tick of the last half-period of a frame. `eof_dly_o` pulses for one cycle after the next tick.
- R12: When `cs_mode_i`=0 (auto), the block checks `txq_empty_i` at the end of the gap phase. If the flag is low, a new setup and frame follow without a new start pulse. If it is high, the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_i | input | DIV_W | Clock divisor; tick period is div_i+1 cycles |
| div_wr_i | input | 1 | Divisor written; restarts the divider count |
| cpol_i | input | 1 | Idle level of SCLK |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges |
| cs_mode_i | input | 2 | 0 auto, 2 hold, 1 or 3 off |
| dly_setup_i | input | DLY_W | Chip-select setup, in SCLK periods |
| dly_hold_i | input | DLY_W | Chip-select hold after a frame, in SCLK periods |
| dly_gap_i | input | DLY_W | Minimum chip-select inactive time, in SCLK periods |
| dly_frame_i | input | DLY_W | Gap between held frames, in SCLK periods |
| frame_len_i | input | LEN_W | Bits per frame |
| start_i | input | 1 | One-cycle transfer request |
| txq_empty_i | input | 1 | Transmit queue empty flag |
| tick_o | output | 1 | Twice-rate clock-enable tick |
| shift_o | output | 1 | Transmit shift strobe |
| sample_o | output | 1 | Receive sample strobe |
| eof_o | output | 1 | End-of-frame pulse |
| eof_dly_o | output | 1 | Delayed end-of-frame pulse |
| busy_o | output | 1 | A transfer sequence is in progress |
| idle_cs_o | output | 1 | Chip select should be deasserted |
| sclk_o | output | 1 | Serial clock pin |

## Verification
The bench builds the block with its default parameters: a 12-bit divisor, 8-bit delays, a 4-bit frame length and a maximum length of 8. It drives divisors of 0 to 3 so that whole frames, holds and gaps finish within a few hundred cycles. The 4-bit length field can carry 0 and values above 8, so the clamp to 8 is reachable. The small divisors also make the every-cycle tick and the divider restart directly observable.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_FGAP,
        ST_HOLD,
        ST_GAP
    } seq_st_e;

    localparam logic [1:0] CSM_AUTO = 2'd0;
    localparam logic [1:0] CSM_HOLD = 2'd2;

endpackage

// File: rtl/spi_sclk_tick.sv
module spi_sclk_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q >= div_i);
        if (restart_i || tick_o) cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/spi_sclk_seq.sv
module spi_sclk_seq
    import spi_sclk_pkg::*;
#(
    parameter int DLY_W   = 8,
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [1:0]       cs_mode_i,
    input  logic [DLY_W-1:0] dly_setup_i,
    input  logic [DLY_W-1:0] dly_hold_i,
    input  logic [DLY_W-1:0] dly_gap_i,
    input  logic [DLY_W-1:0] dly_frame_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic             start_i,
    input  logic             txq_empty_i,
    output logic             shift_o,
    output logic             sample_o,
    output logic             eof_o,
    output logic             eof_dly_o,
    output logic             busy_o,
    output logic             idle_cs_o,
    output logic             sclk_o
);

    localparam int HW = LEN_W + 1;
    localparam int DW = DLY_W + 1;
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

    typedef struct packed {
        seq_st_e       st;
        logic [DW-1:0] dcnt;
        logic [HW-1:0] hcnt;
        logic          sclk;
        logic          pend;
        logic          eofp;
        logic          eof;
        logic          eofd;
        logic          shift;
        logic          sample;
    } seq_t;

    seq_t q, n;

    logic [LEN_W-1:0] len_eff;
    logic [HW-1:0]    hlast;
    logic             more, consume;
    logic             go_setup, go_xfer, go_fgap, go_hold, go_gap, go_after;

    assign len_eff = (frame_len_i == '0 || frame_len_i > LEN_MAX) ? LEN_MAX : frame_len_i;
    assign hlast   = {len_eff, 1'b0} - 1'b1;
    assign more    = ~txq_empty_i;

    always_comb begin
        n        = q;
        n.eof    = 1'b0;
        n.eofd   = 1'b0;
        n.shift  = 1'b0;
        n.sample = 1'b0;
        n.sclk   = (q.st == ST_XFER) ? q.sclk : cpol_i;
        consume  = 1'b0;
        go_setup = 1'b0;
        go_xfer  = 1'b0;
        go_fgap  = 1'b0;
        go_hold  = 1'b0;
        go_gap   = 1'b0;
        go_after = 1'b0;

        if (tick_i) begin
            if (q.eofp) begin
                n.eofd = 1'b1;
                n.eofp = 1'b0;
            end
            case (q.st)
                ST_IDLE: if (q.pend) begin
                    consume  = 1'b1;
                    go_setup = 1'b1;
                end
                ST_SETUP: if (q.dcnt <= DW'(1)) go_xfer = 1'b1;
                          else n.dcnt = q.dcnt - 1'b1;
                ST_XFER: begin
                    n.sclk   = ~q.sclk;
                    n.sample = ~q.hcnt[0] ^ cpha_i;
                    n.shift  =  q.hcnt[0] ^ cpha_i;
                    if (q.hcnt == hlast) begin
                        n.eof  = 1'b1;
                        n.eofp = 1'b1;
                        if (cs_mode_i == CSM_HOLD && more) go_fgap = 1'b1;
                        else                               go_hold = 1'b1;
                    end else begin
                        n.hcnt = q.hcnt + 1'b1;
                    end
                end
                ST_FGAP: if (q.dcnt <= DW'(1)) go_xfer = 1'b1;
                         else n.dcnt = q.dcnt - 1'b1;
                ST_HOLD: if (q.dcnt <= DW'(1)) go_gap = 1'b1;
                         else n.dcnt = q.dcnt - 1'b1;
                ST_GAP:  if (q.dcnt <= DW'(1)) go_after = 1'b1;
                         else n.dcnt = q.dcnt - 1'b1;
                default: n.st = ST_IDLE;
            endcase
        end

        // Resolve chained phase entries; a zero delay skips its phase.
        if (go_hold) begin
            if (dly_hold_i != '0) begin
                n.st   = ST_HOLD;
                n.dcnt = {dly_hold_i, 1'b0};
            end else go_gap = 1'b1;
        end
        if (go_gap) begin
            if (dly_gap_i != '0) begin
                n.st   = ST_GAP;
                n.dcnt = {dly_gap_i, 1'b0};
            end else go_after = 1'b1;
        end
        if (go_after) begin
            if (more) go_setup = 1'b1;
            else      n.st = ST_IDLE;
        end
        if (go_setup) begin
            if (dly_setup_i != '0) begin
                n.st   = ST_SETUP;
                n.dcnt = {dly_setup_i, 1'b0};
            end else go_xfer = 1'b1;
        end
        if (go_fgap) begin
            if (dly_frame_i != '0) begin
                n.st   = ST_FGAP;
                n.dcnt = {dly_frame_i, 1'b0};
            end else go_xfer = 1'b1;
        end
        if (go_xfer) begin
            n.st   = ST_XFER;
            n.hcnt = '0;
        end

        n.pend = start_i | (q.pend & ~consume);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.dcnt   <= '0;
            q.hcnt   <= '0;
            q.sclk   <= 1'b0;
            q.pend   <= 1'b0;
            q.eofp   <= 1'b0;
            q.eof    <= 1'b0;
            q.eofd   <= 1'b0;
            q.shift  <= 1'b0;
            q.sample <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign shift_o   = q.shift;
    assign sample_o  = q.sample;
    assign eof_o     = q.eof;
    assign eof_dly_o = q.eofd;
    assign sclk_o    = q.sclk;
    assign busy_o    = (q.st != ST_IDLE);
    assign idle_cs_o = cs_mode_i[0] | (q.st == ST_IDLE) | (q.st == ST_GAP);

endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
    parameter int DIV_W   = 12,
    parameter int DLY_W   = 8,
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             div_wr_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    input  logic [1:0]       cs_mode_i,
    input  logic [DLY_W-1:0] dly_setup_i,
    input  logic [DLY_W-1:0] dly_hold_i,
    input  logic [DLY_W-1:0] dly_gap_i,
    input  logic [DLY_W-1:0] dly_frame_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic             start_i,
    input  logic             txq_empty_i,
    output logic             tick_o,
    output logic             shift_o,
    output logic             sample_o,
    output logic             eof_o,
    output logic             eof_dly_o,
    output logic             busy_o,
    output logic             idle_cs_o,
    output logic             sclk_o
);

    logic tick;

    spi_sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_i),
        .restart_i (div_wr_i),
        .tick_o    (tick)
    );

    spi_sclk_seq #(.DLY_W(DLY_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .cpol_i      (cpol_i),
        .cpha_i      (cpha_i),
        .cs_mode_i   (cs_mode_i),
        .dly_setup_i (dly_setup_i),
        .dly_hold_i  (dly_hold_i),
        .dly_gap_i   (dly_gap_i),
        .dly_frame_i (dly_frame_i),
        .frame_len_i (frame_len_i),
        .start_i     (start_i),
        .txq_empty_i (txq_empty_i),
        .shift_o     (shift_o),
        .sample_o    (sample_o),
        .eof_o       (eof_o),
        .eof_dly_o   (eof_dly_o),
        .busy_o      (busy_o),
        .idle_cs_o   (idle_cs_o),
        .sclk_o      (sclk_o)
    );

    assign tick_o = tick;

endmodule

// File: rtl/spi_sclk_timer_chk.sv
module spi_sclk_timer_chk #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_i,
    input logic             cpol_i,
    input logic [1:0]       cs_mode_i,
    input logic             tick_o,
    input logic             shift_o,
    input logic             sample_o,
    input logic             eof_o,
    input logic             busy_o,
    input logic             idle_cs_o,
    input logic             sclk_o
);

    p_zero_div_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |-> tick_o);

    p_idle_sclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o) && $past(rst_n) && $stable(cpol_i)) |-> (sclk_o == cpol_i));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_o && sample_o));

    p_strobe_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o || sample_o) |-> $past(tick_o));

    p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> idle_cs_o);

    p_cs_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_mode_i == 2'd1 || cs_mode_i == 2'd3) |-> idle_cs_o);

    p_eof_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);

endmodule

bind spi_sclk_timer spi_sclk_timer_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/spi_sclk_timer_bench.sv
module spi_sclk_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_i = 12'd1;
    logic        div_wr_i = 1'b0;
    logic        cpol_i = 1'b0;
    logic        cpha_i = 1'b0;
    logic [1:0]  cs_mode_i = 2'd0;
    logic [7:0]  dly_setup_i = 8'd1;
    logic [7:0]  dly_hold_i = 8'd1;
    logic [7:0]  dly_gap_i = 8'd1;
    logic [7:0]  dly_frame_i = 8'd0;
    logic [3:0]  frame_len_i = 4'd8;
    logic        start_i = 1'b0;
    logic        txq_empty_i = 1'b1;
    logic tick_o, shift_o, sample_o, eof_o, eof_dly_o, busy_o, idle_cs_o, sclk_o;

    spi_sclk_timer u_spi_sclk_timer (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // Each queue entry is one future tick: kind*100 + half index.
    // kinds: 0 setup, 1 frame, 2 frame gap, 3 hold, 4 cs gap.
    int mq[$];
    int mcnt = 0;
    bit mpend, msclk, meofp, meof, meofd, mshift, msample;

    function automatic int eff_len(input int l);
        return (l == 0 || l > 8) ? 8 : l;
    endfunction

    task automatic push_n(input int kind, input int n);
        for (int i = 0; i < n; i++) mq.push_back(kind * 100);
    endtask

    task automatic push_frame();
        for (int h = 0; h < 2 * eff_len(int'(frame_len_i)); h++) mq.push_back(100 + h);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mcnt = 0; mpend = 0; msclk = 0; meofp = 0;
            meof = 0; meofd = 0; mshift = 0; msample = 0;
        end else begin
            bit t, cons, cur_x;
            int e, h;
            t = (mcnt >= int'(div_i));
            mcnt = (div_wr_i || t) ? 0 : mcnt + 1;
            cons = 0;
            cur_x = (mq.size() > 0) && (mq[0] / 100 == 1);
            if (!cur_x) msclk = cpol_i;
            meof = 0; meofd = 0; mshift = 0; msample = 0;
            if (t) begin
                if (meofp) begin meofd = 1; meofp = 0; end
                if (mq.size() == 0) begin
                    if (mpend) begin
                        cons = 1;
                        push_n(0, 2 * int'(dly_setup_i));
                        push_frame();
                    end
                end else begin
                    e = mq.pop_front();
                    if (e / 100 == 1) begin
                        h = e % 100;
                        msclk = !msclk;
                        msample = ((h % 2) == 0) == (cpha_i == 1'b0);
                        mshift = !msample;
                        if (h == 2 * eff_len(int'(frame_len_i)) - 1) begin
                            meof = 1; meofp = 1;
                            if (cs_mode_i == 2'd2 && !txq_empty_i) begin
                                push_n(2, 2 * int'(dly_frame_i));
                                push_frame();
                            end else begin
                                push_n(3, 2 * int'(dly_hold_i));
                                push_n(4, 2 * int'(dly_gap_i));
                            end
                        end
                    end
                    if (mq.size() == 0 && !txq_empty_i) begin
                        push_n(0, 2 * int'(dly_setup_i));
                        push_frame();
                    end
                end
            end
            mpend = start_i | (mpend & !cons);
        end
    end

    // ---------------- per-cycle comparison and event counters ----------------
    int n_eof = 0, n_shift = 0, n_sample = 0, n_tick = 0, n_tog = 0;
    int n_cs_hi_busy = 0, n_cs_lo = 0;
    bit sclk_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit ebusy, eidle, etick;
            etick = (mcnt >= int'(div_i));
            ebusy = (mq.size() != 0);
            eidle = cs_mode_i[0] || !ebusy || (mq[0] / 100 == 4);
            chk(tick_o == etick, "R1 tick", tick_o, etick);
            chk(sclk_o == msclk, "R4 sclk", sclk_o, msclk);
            chk(shift_o == mshift, "R5 shift", shift_o, mshift);
            chk(sample_o == msample, "R5 sample", sample_o, msample);
            chk(eof_o == meof, "R11 eof", eof_o, meof);
            chk(eof_dly_o == meofd, "R11 eof_dly", eof_dly_o, meofd);
            chk(busy_o == ebusy, "R7 busy", busy_o, ebusy);
            chk(idle_cs_o == eidle, "R8 idle_cs", idle_cs_o, eidle);
            if (eof_o) n_eof++;
            if (shift_o) n_shift++;
            if (sample_o) n_sample++;
            if (tick_o) n_tick++;
            if (sclk_o != sclk_prev) n_tog++;
            if (idle_cs_o && busy_o) n_cs_hi_busy++;
            if (!idle_cs_o) n_cs_lo++;
            sclk_prev = sclk_o;
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        step(1);
        start_i = 1'b1;
        step(1);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        int g;
        g = 0;
        while (!busy_o && g < 2000) begin @(negedge clk); g++; end
        g = 0;
        while (busy_o && g < 40000) begin @(negedge clk); g++; end
        step(4);
    endtask

    task automatic wait_eofs(input int base, input int n);
        int g;
        g = 0;
        while (n_eof - base < n && g < 40000) begin @(negedge clk); g++; end
    endtask

    initial begin
        int b0, b1, b2, b3;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state
        chk(busy_o == 1'b0, "R3 busy after reset", busy_o, 0);
        chk(idle_cs_o == 1'b1, "R3 idle_cs after reset", idle_cs_o, 1);
        chk(sclk_o == 1'b0, "R3 sclk after reset", sclk_o, 0);

        // Scenario 1: one auto-mode frame, setup/hold/gap of 1 (R7, R8, R11)
        step(1);
        b0 = n_eof;
        pulse_start();
        wait_idle();
        chk(n_eof - b0 == 1, "R11 single frame eof count", n_eof - b0, 1);

        // Scenario 2: divisor 0, cpol 1, cpha 1, length 0 (R2, R6)
        div_i = 12'd0; cpol_i = 1'b1; cpha_i = 1'b1; frame_len_i = 4'd0;
        step(3);
        b0 = n_tick;
        step(20);
        chk(n_tick - b0 == 20, "R2 tick every cycle", n_tick - b0, 20);
        chk(sclk_o == 1'b1, "R3 idle sclk follows cpol", sclk_o, 1);
        b0 = n_shift; b1 = n_sample;
        pulse_start();
        wait_idle();
        chk(n_shift - b0 == 8, "R6 length 0 gives 8 shifts", n_shift - b0, 8);
        chk(n_sample - b1 == 8, "R6 length 0 gives 8 samples", n_sample - b1, 8);

        // Scenario 3: divisor 2, length 5, all delays zero, length 12 later (R1, R4, R6)
        div_i = 12'd2; cpol_i = 1'b0; cpha_i = 1'b0; frame_len_i = 4'd5;
        dly_setup_i = 8'd0; dly_hold_i = 8'd0; dly_gap_i = 8'd0;
        div_wr_i = 1'b1;
        step(1);
        div_wr_i = 1'b0;
        step(2);
        b0 = n_tick;
        step(30);
        chk(n_tick - b0 == 10, "R1 tick every div+1 cycles", n_tick - b0, 10);
        b0 = n_tog; b1 = n_shift;
        pulse_start();
        wait_idle();
        chk(n_tog - b0 == 10, "R4 sclk toggles 2L times", n_tog - b0, 10);
        chk(n_shift - b1 == 5, "R6 length 5 gives 5 shifts", n_shift - b1, 5);
        chk(sclk_o == 1'b0, "R4 sclk back at cpol", sclk_o, 0);
        frame_len_i = 4'd12;
        b0 = n_sample;
        pulse_start();
        wait_idle();
        chk(n_sample - b0 == 8, "R6 length 12 clamps to 8", n_sample - b0, 8);

        // Scenario 4: hold mode with queued data (R9)
        div_i = 12'd1; frame_len_i = 4'd8; cs_mode_i = 2'd2;
        dly_setup_i = 8'd1; dly_hold_i = 8'd1; dly_gap_i = 8'd1; dly_frame_i = 8'd2;
        txq_empty_i = 1'b0;
        b0 = n_eof; b1 = n_cs_hi_busy;
        pulse_start();
        wait_eofs(b0, 2);
        step(1);
        txq_empty_i = 1'b1;
        wait_idle();
        chk(n_eof - b0 == 3, "R9 held frames eof count", n_eof - b0, 3);
        chk(n_cs_hi_busy - b1 == 4, "R9 cs inactive only in final gap", n_cs_hi_busy - b1, 4);

        // Scenario 5: auto mode continues while data is queued (R12)
        cs_mode_i = 2'd0;
        txq_empty_i = 1'b0;
        b2 = n_eof;
        pulse_start();
        wait_eofs(b2, 2);
        step(1);
        txq_empty_i = 1'b1;
        wait_idle();
        chk(n_eof - b2 == 2, "R12 auto frames without new start", n_eof - b2, 2);

        // Scenario 6: chip select off (R10)
        cs_mode_i = 2'd1;
        b3 = n_cs_lo;
        pulse_start();
        wait_idle();
        cs_mode_i = 2'd3;
        pulse_start();
        wait_idle();
        chk(n_cs_lo - b3 == 0, "R10 off mode never asserts cs", n_cs_lo - b3, 0);

        // Scenario 7: divisor rewrite in the middle of a frame (R1)
        cs_mode_i = 2'd0; div_i = 12'd3;
        pulse_start();
        step(12);
        div_i = 12'd2;
        div_wr_i = 1'b1;
        step(1);
        div_wr_i = 1'b0;
        wait_idle();
        chk(busy_o == 1'b0, "R1 sequence completes after divisor rewrite", busy_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule